// File: doc/BRIEF.md
# Dual-Rail Precharge Bitwise Operator

This block applies a two-input bitwise operation to a vector of dual-rail encoded bits. Each logical bit travels on a two-wire pair: one rail carries the true value and the other carries the false value. The caller alternates two phases. In the precharge phase every pair is cleared to zero. In the evaluation phase exactly one rail of each pair rises. The result is therefore built from a reference state that does not depend on the data, and the number of rails that switch is the same for every value.

Each lane finds its result in a fixed 16-entry table. The table index is the lane's two operand pairs placed side by side. Any index that does not join two legal codes gives the empty pair. A single upset rail therefore erases the lane's value, and every later stage that uses the lane inherits the error. A registered fault flag reports illegal pairs. The result register reloads only after it has passed through the cleared state.

Top module: `dr_bitop_unit`

## Requirements
- R1: After a clock edge with `rst` high, `y_o` is all zero and `fault_o` is low.
- R2: After a clock edge with `eval_i` low (precharge), every pair of `y_o` is 2'b00.
- R3: Lane i occupies bits [2i+1:2i], and bit 2i is the true rail. Logical 0 is 2'b10 and logical 1 is 2'b01. Opcode 2'b00 gives the AND of the lanes of a and b in this encoding.
- R4: Opcode 2'b01 gives the lane-wise OR, in the R3 encoding.
- R5: Opcode 2'b10 gives the lane-wise XOR, in the R3 encoding.
- R6: Opcode 2'b11 inverts a by swapping its two rails. The b operand has no effect on the result.
- R7: For opcodes 2'b00, 2'b01 and 2'b10, a lane whose a or b pair is 2'b00 or 2'b11 gives 2'b00. The other lanes are not affected.
- R8: When a result is loaded in evaluation, `fault_o` goes high if any lane's result pair is 2'b00 or 2'b11. It also goes high if any lane has an a pair, or (for opcodes other than 2'b11) a b pair, equal to 2'b00 or 2'b11.
- R9: After a precharge edge, `fault_o` equals the OR of all bits of `a_i` and `b_i`.
- R10: Once a result is loaded, further evaluation edges hold `y_o` and `fault_o` unchanged. The next result can load only after at least one precharge edge.
- R11: A result appears on `y_o` on the first clock edge that samples `eval_i` high after a precharge or a reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| eval_i | input | 1 | 1 = evaluation phase, 0 = precharge phase |
| op_i | input | 2 | Operation: 00 AND, 01 OR, 10 XOR, 11 invert a |
| a_i | input | 2*LANES | Operand a, one rail pair per lane |
| b_i | input | 2*LANES | Operand b, one rail pair per lane |
| y_o | output | 2*LANES | Registered result pairs |
| fault_o | output | 1 | Registered illegal-code flag |

## Verification
The assertions check these properties on every cycle:
- After precharge the output is cleared.
- Reset clears both outputs.
- A loaded result is held while evaluation continues.
- For the three table operations, an illegal operand never produces anything other than the empty pair, and no legal pair of operands produces the 2'b11 code.
- A registered output that contains an illegal pair always comes with the fault flag.

The truth tables under the encoding need the bench's scenarios, because they depend on the values chosen for the operands. The same holds for the independence of the lanes, for the rule that b has no effect on inversion, and for the precharge fault flag.

// File: rtl/dr_bitop_pkg.sv
package dr_bitop_pkg;

  typedef enum logic [1:0] {
    OP_AND = 2'b00,
    OP_OR  = 2'b01,
    OP_XOR = 2'b10,
    OP_INV = 2'b11
  } dr_op_e;

  localparam logic [1:0] PAIR_EMPTY = 2'b00;
  localparam logic [1:0] PAIR_ZERO  = 2'b10;
  localparam logic [1:0] PAIR_ONE   = 2'b01;

  // A pair is a legal code when exactly one rail is high.
  function automatic logic pair_legal(input logic [1:0] p);
    return p[0] ^ p[1];
  endfunction

endpackage

// File: rtl/dr_lut_lane.sv
module dr_lut_lane
  import dr_bitop_pkg::*;
(
  input  dr_op_e     op_i,
  input  logic [1:0] a_pair_i,
  input  logic [1:0] b_pair_i,
  output logic [1:0] res_o,
  output logic       bad_o
);

  logic [3:0] idx;
  assign idx = {a_pair_i, b_pair_i};

  always_comb begin
    res_o = PAIR_EMPTY;
    unique case (op_i)
      OP_AND: begin
        unique case (idx)
          4'b0101:                   res_o = PAIR_ONE;
          4'b0110, 4'b1001, 4'b1010: res_o = PAIR_ZERO;
          default:                   res_o = PAIR_EMPTY;
        endcase
      end
      OP_OR: begin
        unique case (idx)
          4'b0101, 4'b0110, 4'b1001: res_o = PAIR_ONE;
          4'b1010:                   res_o = PAIR_ZERO;
          default:                   res_o = PAIR_EMPTY;
        endcase
      end
      OP_XOR: begin
        unique case (idx)
          4'b0110, 4'b1001:          res_o = PAIR_ONE;
          4'b0101, 4'b1010:          res_o = PAIR_ZERO;
          default:                   res_o = PAIR_EMPTY;
        endcase
      end
      OP_INV: res_o = {a_pair_i[0], a_pair_i[1]};
      default: res_o = PAIR_EMPTY;
    endcase
  end

  // Lane fault: illegal a, illegal b (when b is used), or illegal result.
  always_comb begin
    bad_o = !pair_legal(a_pair_i) || !pair_legal(res_o);
    if (op_i != OP_INV) bad_o = bad_o || !pair_legal(b_pair_i);
  end

  // R7: an illegal operand in a table operation always gives the empty pair.
  // R3: table operations never emit 2'b11.
  always_comb begin
    if (op_i != OP_INV) begin
      a_r7_infect: assert (pair_legal(a_pair_i) && pair_legal(b_pair_i) || res_o == PAIR_EMPTY)
        else $error("illegal operand produced a non-empty result");
      a_r3_no_eleven: assert (res_o != 2'b11)
        else $error("table produced the 11 code");
    end
  end

endmodule

// File: rtl/dr_precharge_reg.sv
module dr_precharge_reg #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             eval_i,
  input  logic [WIDTH-1:0] res_i,
  input  logic             eval_fault_i,
  input  logic             pre_fault_i,
  output logic [WIDTH-1:0] y_o,
  output logic             fault_o
);

  // armed: the register has been cleared and may accept one new result.
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      y_o     <= '0;
      fault_o <= 1'b0;
      armed_q <= 1'b1;
    end else if (!eval_i) begin
      y_o     <= '0;
      fault_o <= pre_fault_i;
      armed_q <= 1'b1;
    end else if (armed_q) begin
      y_o     <= res_i;
      fault_o <= eval_fault_i;
      armed_q <= 1'b0;
    end
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (y_o == '0 && !fault_o && armed_q))
    else $error("reset did not clear outputs");

  a_r2_precharge_zero: assert property (@(posedge clk) disable iff (rst)
    !eval_i |=> (y_o == '0))
    else $error("precharge left a rail high");

  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (eval_i && !armed_q) |=> ($stable(y_o) && $stable(fault_o)))
    else $error("loaded result overwritten without precharge");

endmodule

// File: rtl/dr_bitop_unit.sv
module dr_bitop_unit
  import dr_bitop_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               eval_i,
  input  logic [1:0]         op_i,
  input  logic [2*LANES-1:0] a_i,
  input  logic [2*LANES-1:0] b_i,
  output logic [2*LANES-1:0] y_o,
  output logic               fault_o
);

  localparam int W = 2 * LANES;

  dr_op_e           op;
  logic [W-1:0]     res_vec;
  logic [LANES-1:0] bad_vec;
  logic [LANES-1:0] y_bad;
  logic             pre_fault;
  logic             eval_fault;

  assign op = dr_op_e'(op_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    dr_lut_lane u_lane (
      .op_i     (op),
      .a_pair_i (a_i[2*g +: 2]),
      .b_pair_i (b_i[2*g +: 2]),
      .res_o    (res_vec[2*g +: 2]),
      .bad_o    (bad_vec[g])
    );
    assign y_bad[g] = !pair_legal(y_o[2*g +: 2]);
  end

  assign eval_fault = |bad_vec;
  assign pre_fault  = |{a_i, b_i};

  dr_precharge_reg #(.WIDTH(W)) u_reg (
    .clk          (clk),
    .rst          (rst),
    .eval_i       (eval_i),
    .res_i        (res_vec),
    .eval_fault_i (eval_fault),
    .pre_fault_i  (pre_fault),
    .y_o          (y_o),
    .fault_o      (fault_o)
  );

  // R8: a loaded output carrying an illegal pair is always flagged.
  a_r8_fault_covers_output: assert property (@(posedge clk) disable iff (rst)
    (y_o != '0 && (|y_bad)) |-> fault_o)
    else $error("illegal output pair without fault flag");

endmodule

// File: tb/test_dr_bitop_unit.sv
`timescale 1ns/1ps
module test_dr_bitop_unit;

  localparam int LANES = 8;
  localparam int W = 2 * LANES;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         eval_i = 1'b0;
  logic [1:0]   op_i = 2'b00;
  logic [W-1:0] a_i = '0;
  logic [W-1:0] b_i = '0;
  logic [W-1:0] y_o;
  logic         fault_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  logic [W-1:0] exp_y = '0;
  logic         exp_f = 1'b0;
  bit           armed = 1'b1;

  always #2.5 clk = ~clk;

  dr_bitop_unit #(.LANES(LANES)) i_dr_bitop_unit (
    .clk(clk), .rst(rst), .eval_i(eval_i), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .y_o(y_o), .fault_o(fault_o)
  );

  function automatic bit legal(input logic [1:0] p);
    return (p == 2'b01) || (p == 2'b10);
  endfunction

  // Reference from the encoding rules: 01 means 1, 10 means 0.
  function automatic logic [1:0] ref_lane(input logic [1:0] op, input logic [1:0] ap,
                                          input logic [1:0] bp);
    bit va, vb, r;
    if (op == 2'b11) return {ap[0], ap[1]};
    if (!legal(ap) || !legal(bp)) return 2'b00;
    va = (ap == 2'b01);
    vb = (bp == 2'b01);
    if (op == 2'b00)      r = va & vb;
    else if (op == 2'b01) r = va | vb;
    else                  r = va ^ vb;
    return r ? 2'b01 : 2'b10;
  endfunction

  function automatic logic [W-1:0] ref_vec(input logic [1:0] op, input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int i = 0; i < LANES; i++) r[2*i +: 2] = ref_lane(op, a[2*i +: 2], b[2*i +: 2]);
    return r;
  endfunction

  function automatic logic ref_fault(input logic [1:0] op, input logic [W-1:0] a,
                                     input logic [W-1:0] b);
    logic f;
    f = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (!legal(a[2*i +: 2])) f = 1'b1;
      if (op != 2'b11 && !legal(b[2*i +: 2])) f = 1'b1;
      if (!legal(ref_lane(op, a[2*i +: 2], b[2*i +: 2]))) f = 1'b1;
    end
    return f;
  endfunction

  function automatic bit any_illegal(input logic [1:0] op, input logic [W-1:0] a,
                                     input logic [W-1:0] b);
    for (int i = 0; i < LANES; i++)
      if (!legal(a[2*i +: 2]) || (op != 2'b11 && !legal(b[2*i +: 2]))) return 1'b1;
    return 1'b0;
  endfunction

  function automatic string op_tag(input logic [1:0] op, input logic [W-1:0] a,
                                   input logic [W-1:0] b);
    if (any_illegal(op, a, b)) return "R7";
    case (op)
      2'b00:   return "R3";
      2'b01:   return "R4";
      2'b10:   return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [W-1:0] rand_legal();
    logic [W-1:0] v;
    for (int i = 0; i < LANES; i++) v[2*i +: 2] = ($urandom % 2) ? 2'b01 : 2'b10;
    return v;
  endfunction

  function automatic logic [W-1:0] rand_raw();
    return W'($urandom);
  endfunction

  task automatic check_vec(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: y_o actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: fault_o actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Called at a negative edge: drive, let one rising edge pass, check.
  task automatic step(input logic ev, input logic [1:0] op, input logic [W-1:0] a,
                      input logic [W-1:0] b, input string ytag);
    string ftag;
    eval_i = ev; op_i = op; a_i = a; b_i = b;
    @(posedge clk);
    if (!ev) begin
      exp_y = '0;
      exp_f = |{a, b};
      armed = 1'b1;
      ftag  = "R9";
    end else if (armed) begin
      exp_y = ref_vec(op, a, b);
      exp_f = ref_fault(op, a, b);
      armed = 1'b0;
      ftag  = "R8";
    end else begin
      ftag  = "R10";
    end
    @(negedge clk);
    check_vec(ytag, y_o, exp_y);
    check_bit(ftag, fault_o, exp_f);
  endtask

  task automatic do_eval(input logic [1:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    step(1'b1, op, a, b, op_tag(op, a, b));
  endtask

  task automatic do_pre(input logic [W-1:0] a, input logic [W-1:0] b);
    step(1'b0, 2'b00, a, b, "R2");
  endtask

  // Lanes 0..3 and 4..7 cover all four legal operand combinations.
  localparam logic [W-1:0] DIR_A = 16'b01_01_10_10_01_01_10_10;
  localparam logic [W-1:0] DIR_B = 16'b01_10_01_10_01_10_01_10;
  // Illegal lanes mixed with legal ones.
  localparam logic [W-1:0] BAD_A = 16'b01_10_11_00_01_11_00_01;
  localparam logic [W-1:0] BAD_B = 16'b01_11_01_10_00_01_10_01;

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_vec("R1", y_o, '0);
    check_bit("R1", fault_o, 1'b0);
    rst = 1'b0;

    // R11: first evaluation after reset loads at once.
    step(1'b1, 2'b00, DIR_A, DIR_B, "R11");
    do_pre('0, '0);
    do_eval(2'b01, DIR_A, DIR_B);
    do_pre('0, '0);
    do_eval(2'b10, DIR_A, DIR_B);
    do_pre('0, '0);
    do_eval(2'b11, DIR_A, DIR_B);
    do_pre('0, '0);
    // R6: b must not matter for inversion, even when illegal.
    do_eval(2'b11, DIR_A, BAD_B);
    do_pre('0, '0);
    // R7: illegal lanes collapse, legal lanes computed.
    for (int op = 0; op < 3; op++) begin
      do_eval(2'(op), BAD_A, BAD_B);
      do_pre('0, '0);
    end
    // R10: second evaluation with other inputs must not overwrite.
    do_eval(2'b00, DIR_A, DIR_B);
    step(1'b1, 2'b10, ~DIR_A, BAD_B, "R10");
    // R9: precharge with nonzero inputs raises fault, R2 clears output.
    do_pre(DIR_A, '0);
    do_pre('0, '0);

    for (int it = 0; it < 400; it++) begin
      logic [1:0]   op;
      logic [W-1:0] a, b;
      op = 2'($urandom % 4);
      if ($urandom % 10 < 7) begin a = rand_legal(); b = rand_legal(); end
      else begin a = rand_raw(); b = rand_raw(); end
      if ($urandom % 10 == 0) do_pre(rand_raw(), rand_raw());
      else do_pre('0, '0);
      do_eval(op, a, b);
      if ($urandom % 4 == 0) step(1'b1, 2'($urandom % 4), rand_raw(), rand_raw(), "R10");
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule